// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio. It uses the pulse-swallow method to do so. A dual-modulus prescaler divides by 65 or by 64. A 6-bit swallow count and a 12-bit main count choose, for each output period, how many prescaler cycles run at each modulus. The result is one output pulse every 64·N + A input clocks. This output feeds the phase comparator of a frequency synthesizer loop.

At the start of each output period, the swallow and main counters reload. The prescaler runs at 65 for the first A prescaler cycles and at 64 for the remaining N − A cycles.

A new pair of values is presented with a one-clock load strobe. A legal pair is held aside and takes effect only at the next output-period boundary, so no period of odd length is ever produced. A pair that breaks the rules raises an error flag and is discarded, and the last legal setting stays in force.

Top module: `psw_divider`

## Requirements
- R1: While reset is high, and on the first clock after it, both `fp` and `cfg_err` are 0.
- R2: After reset, with no load, the output period is 64·DEF_N + DEF_A input clocks (defaults DEF_A = 3, DEF_N = 8, giving 515).
- R3: After a legal load (A in 0..63, N in 5..4095, N > A), each output period is 64·N + A input clocks. This gives 320 for A=0/N=5, 324 for A=4/N=5, 4159 for A=63/N=64, and 6417 for A=17/N=100. No two pulses are ever closer than 64·5 clocks.
- R4: A legal load issued during an output period does not change that period. The new ratio applies from the following period onward.
- R5: A load with N < 5 sets `cfg_err` on the next clock, and the period stays at the previous legal setting.
- R6: A load with A ≥ N sets `cfg_err` on the next clock, and the period stays at the previous legal setting.
- R7: A legal load clears `cfg_err` on the next clock. Without a load, `cfg_err` keeps its value.
- R8: `fp` is high for exactly one input clock per output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-clock strobe that presents a new A/N pair |
| a_val | input | 6 | Swallow value A |
| n_val | input | 12 | Main value N |
| fp | output | 1 | Divided output, one clock wide per period |
| cfg_err | output | 1 | Last loaded pair was illegal |

## Verification
The period is measured from pulse to pulse for five settings:
- the reset default;
- A = 0, a pure divide-by-64 run that shows the 65 modulus is never selected when no swallow is asked for;
- the largest A allowed for the smallest N (4 with 5), which probes the N > A edge;
- A = 63 with N = 64;
- an interior pair.

Each setting is seen in a period whose length tells it apart from the settings before and after it. Loads are issued just after a pulse, so a design that applied them at once would give a wrong-length period in the middle of the run. Illegal pairs of both kinds (N too small, and A not below N) are shown to raise the flag and to leave the period unchanged.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int A_W = 6;
  localparam int N_W = 12;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [N_W-1:0] n;
  } div_cfg_t;
endpackage

// File: rtl/psw_cfg.sv
module psw_cfg
  import psw_pkg::*;
#(
  parameter int N_MIN = 5,
  parameter int DEF_A = 3,
  parameter int DEF_N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           boundary,
  output div_cfg_t       nxt_cfg,
  output logic           err
);
  localparam int PAD_W = N_W - A_W;

  div_cfg_t act_q, pend_q;
  logic     pend_vld_q;
  logic     legal;

  assign legal = (n_in >= N_W'(N_MIN)) && (n_in > {{PAD_W{1'b0}}, a_in});
  assign nxt_cfg = pend_vld_q ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= '{a: A_W'(DEF_A), n: N_W'(DEF_N)};
      pend_q     <= '{a: A_W'(DEF_A), n: N_W'(DEF_N)};
      pend_vld_q <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (boundary && pend_vld_q) act_q <= pend_q;
      if (load && legal) begin
        pend_q     <= '{a: a_in, n: n_in};
        pend_vld_q <= 1'b1;
        err        <= 1'b0;
      end else begin
        if (boundary) pend_vld_q <= 1'b0;
        if (load) err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int P_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  output logic tc
);
  localparam int M = 2 ** P_W;

  logic [P_W:0] cnt_q;

  assign tc = (cnt_q == (sel_hi ? (P_W+1)'(M) : (P_W+1)'(M - 1)));

  always_ff @(posedge clk) begin
    if (rst || tc) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int DEF_A = 3,
  parameter int DEF_N = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tc,
  input  div_cfg_t nxt_cfg,
  output logic     sel_hi,
  output logic     boundary,
  output logic     fp
);
  logic [A_W-1:0] sw_q;
  logic [N_W-1:0] mn_q;

  assign sel_hi   = (sw_q != '0);
  assign boundary = tc && (mn_q == N_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= A_W'(DEF_A);
      mn_q <= N_W'(DEF_N);
      fp   <= 1'b0;
    end else begin
      fp <= boundary;
      if (boundary) begin
        sw_q <= nxt_cfg.a;
        mn_q <= nxt_cfg.n;
      end else if (tc) begin
        if (sel_hi) sw_q <= sw_q - 1'b1;
        mn_q <= mn_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int P_W   = 6,
  parameter int N_MIN = 5,
  parameter int DEF_A = 3,
  parameter int DEF_N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_val,
  input  logic [N_W-1:0] n_val,
  output logic           fp,
  output logic           cfg_err
);
  div_cfg_t nxt_cfg;
  logic     tc, sel_hi, boundary;

  psw_cfg #(.N_MIN(N_MIN), .DEF_A(DEF_A), .DEF_N(DEF_N)) u_cfg (
    .clk(clk), .rst(rst), .load(load), .a_in(a_val), .n_in(n_val),
    .boundary(boundary), .nxt_cfg(nxt_cfg), .err(cfg_err)
  );

  psw_prescaler #(.P_W(P_W)) u_pre (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .tc(tc)
  );

  psw_ctrl #(.DEF_A(DEF_A), .DEF_N(DEF_N)) u_ctrl (
    .clk(clk), .rst(rst), .tc(tc), .nxt_cfg(nxt_cfg),
    .sel_hi(sel_hi), .boundary(boundary), .fp(fp)
  );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int P_W   = 6,
  parameter int N_MIN = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        load,
  input logic [5:0]  a_val,
  input logic [11:0] n_val,
  input logic        fp,
  input logic        cfg_err
);
  localparam int MIN_GAP = (2 ** P_W) * N_MIN;

  logic [19:0] gap_q;
  logic        seen_q;
  logic        bad_pair;

  assign bad_pair = (n_val < 12'(N_MIN)) || (n_val <= {6'd0, a_val});

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (fp) begin
      gap_q  <= 20'd1;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!fp && !cfg_err));

  // R8
  fp_single_chk: assert property (@(posedge clk) disable iff (rst) fp |=> !fp);

  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fp && seen_q) |-> (gap_q >= 20'(MIN_GAP)));

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (load && bad_pair) |=> cfg_err);

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !bad_pair) |=> !cfg_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !$past(rst)) |=> $stable(cfg_err));
endmodule

bind psw_divider psw_divider_chk #(.P_W(P_W), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst(rst), .load(load), .a_val(a_val), .n_val(n_val),
  .fp(fp), .cfg_err(cfg_err)
);

// File: tb/psw_divider_tb.sv
`timescale 1ns/1ps
module psw_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [5:0]  a_val = '0;
  logic [11:0] n_val = '0;
  logic        fp, cfg_err;

  int tests = 0, fails = 0;
  int cyc = 0, last_pulse = 0;
  int exp_q[$];
  string tag_q[$];
  int cur_period;
  string cur_tag;
  bit width_chk = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psw_divider u_dut (
    .clk(clk), .rst(rst), .load(load), .a_val(a_val), .n_val(n_val),
    .fp(fp), .cfg_err(cfg_err)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // monitor: period scoreboard and pulse width
  always @(negedge clk) begin
    if (!rst) begin
      if (width_chk) begin
        tests++;
        if (fp) begin fails++; $display("FAIL R8 fp width got 2+ expected 1"); end
        width_chk = 0;
      end
      if (fp) begin
        int got, ex;
        string tg;
        got = cyc - last_pulse;
        last_pulse = cyc;
        width_chk = 1;
        if (exp_q.size() > 0) begin
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          tests++;
          if (got != ex) begin
            fails++;
            $display("FAIL %s period got %0d expected %0d", tg, got, ex);
          end
        end
      end
    end
  end

  task automatic wait_pulse_push();
    do @(negedge clk); while (!fp);
    exp_q.push_back(cur_period);
    tag_q.push_back(cur_tag);
  endtask

  task automatic run(int k);
    repeat (k) wait_pulse_push();
  endtask

  task automatic step(int a, int n, bit legal, string tg);
    wait_pulse_push();        // period now running keeps the old ratio (R4)
    a_val = 6'(a); n_val = 12'(n); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    tests++;
    if (cfg_err != !legal) begin
      fails++;
      $display("FAIL %s cfg_err got %0d expected %0d", tg, cfg_err, !legal);
    end
    if (legal) cur_period = 64 * n + a;
    cur_tag = tg;
  endtask

  initial begin
    #200_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;                                   // R1
    if (fp !== 1'b0 || cfg_err !== 1'b0) begin
      fails++; $display("FAIL R1 fp/err got %b%b expected 00", fp, cfg_err);
    end
    rst = 1'b0;
    @(negedge clk);
    tests++;                                   // R1 first clock after reset
    if (fp !== 1'b0 || cfg_err !== 1'b0) begin
      fails++; $display("FAIL R1 after release got %b%b expected 00", fp, cfg_err);
    end
    cur_period = 515; cur_tag = "R2";
    exp_q.push_back(cur_period); tag_q.push_back(cur_tag);
    run(1);
    step(0, 5, 1, "R3");    run(2);            // pure /64
    step(4, 5, 1, "R4");    run(2);            // A = N-1 edge
    step(0, 4, 0, "R5");    run(2);            // N below minimum
    step(63, 64, 1, "R7");  run(2);            // clears flag
    step(20, 20, 0, "R6");  run(1);            // A not below N
    step(17, 100, 1, "R3"); run(1);
    step(9, 6, 0, "R6");    run(1);
    do @(negedge clk); while (!fp);            // drain last period
    @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R3 pending periods got %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule